// File: doc/BRIEF.md
# Serial Synthesizer Control Register Interface

This block is the write-only control port of a frequency synthesizer. A host drives three wires: a serial clock, a serial data line and an active-low enable. While the enable is low, every rising edge of the serial clock shifts one bit into a frame register. When the enable rises, the frame is decoded and written into a small register file. The register file holds a main configuration word, two power-control bits, two RF divider values and one IF divider value. The three serial wires are treated as asynchronous inputs. They are synchronized to the system clock `clk` before any edge is detected.

From the stored bits and an active-low hardware power pin, the block derives four control outputs: an IF section enable, an RF section enable, a reference-amplifier enable and an RF band select. The band select names the RF path that drives the shared output. It follows whichever RF divider register was written last. The divider values and configuration fields are presented on ports so the analog side can use them directly.

Top module: `synth_ctl_port`

## Requirements
- R1: A frame is 22 bits, sent most significant bit first: the 18 data bits D17..D0 first, then the 4 address bits A3..A0. The data field is stored into the register that the address selects.
- R2: A bit is shifted only on a rising edge of `ser_clk` that occurs while `ser_en_n` is low. Serial clock edges while `ser_en_n` is high leave the frame register unchanged.
- R3: A write takes place on the rising edge of `ser_en_n` and uses only the last 22 bits shifted. Any earlier bits in the same frame are discarded.
- R4: Address 0 is the main configuration register. Data bits 13:12 appear on `aux_sel`, bit 5 appears on `low_pwr` and bit 3 appears on `auto_on`. Its other data bits are not stored.
- R5: Address 2 is the power-control register: bit 1 drives `if_on_bit` and bit 0 drives `rf_on_bit`. Address 3 stores 18 bits into `n_rf1` and address 4 stores 18 bits into `n_rf2`. Address 5 stores data bits 15:0 into `n_if`, and its bits 17:16 are ignored.
- R6: While `hw_pwr_n` is low, `if_en`, `rf_en` and `ref_en` are all 0, whatever the register contents.
- R7: While `hw_pwr_n` is high, `if_en` equals `if_on_bit` and `rf_en` equals `rf_on_bit`. When `auto_on` is 1, both enables are 1 regardless of those bits.
- R8: `ref_en` is 1 exactly when `if_en` or `rf_en` is 1.
- R9: A write to address 3 sets `rf_band` to 0 (RF1). A write to address 4 sets it to 1 (RF2). Writes to other addresses leave `rf_band` unchanged.
- R10: Serial writes are accepted and take effect in every power state, including while `hw_pwr_n` is low.
- R11: Writes to addresses 1 and 6 through 15 are dropped. No stored register and no output changes.
- R12: A synchronous reset (`rst` high at a `clk` edge) clears every register to zero and selects RF1 (`rf_band` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| hw_pwr_n | input | 1 | Active-low hardware power-down pin |
| aux_sel | output | 2 | Auxiliary output select field from the main configuration |
| low_pwr | output | 1 | Low-power output-level flag from the main configuration |
| auto_on | output | 1 | Forces both sections on when 1 |
| if_on_bit | output | 1 | Stored IF section power bit |
| rf_on_bit | output | 1 | Stored RF section power bit |
| n_rf1 | output | 18 | RF1 divider value |
| n_rf2 | output | 18 | RF2 divider value |
| n_if | output | 16 | IF divider value |
| rf_band | output | 1 | RF path select: 0 = RF1, 1 = RF2 |
| if_en | output | 1 | IF section enable |
| rf_en | output | 1 | RF section enable |
| ref_en | output | 1 | Reference amplifier enable |

## Verification
The assertions check the following on every cycle:
- the power-state outputs are forced off while the pin is low;
- the auto-on flag forces both enables;
- the reference enable follows the section enables;
- the frame register holds still while the enable is high;
- stored registers change only on a frame commit or a reset;
- a change of either RF divider comes with the matching band select.

The bench scenarios are needed to show the exact bit positions of each field, the discarding of leading bits, and the dropping of reserved addresses. They also show that ignored serial clocks leave no trace in a later empty frame, and that writes still land while the hardware pin holds the part down.

// File: rtl/synth_ctl_port.sv
module synth_ctl_port #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 4,
  parameter int IF_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en_n,
  input  logic              hw_pwr_n,
  output logic [1:0]        aux_sel,
  output logic              low_pwr,
  output logic              auto_on,
  output logic              if_on_bit,
  output logic              rf_on_bit,
  output logic [DATA_W-1:0] n_rf1,
  output logic [DATA_W-1:0] n_rf2,
  output logic [IF_W-1:0]   n_if,
  output logic              rf_band,
  output logic              if_en,
  output logic              rf_en,
  output logic              ref_en
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int AUX_LSB = 12;
  localparam int LPW_BIT = 5;
  localparam int AUT_BIT = 3;
  localparam int PDI_BIT = 1;
  localparam int PDR_BIT = 0;
  localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_NRF1 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_NRF2 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_NIF  = ADDR_W'(5);

  logic [SYNC_STAGES-1:0] sck_sy, sen_sy, sda_sy;
  logic                   sck_q, sen_q;
  logic [FRAME_W-1:0]     shreg;

  wire sck      = sck_sy[SYNC_STAGES-1];
  wire sen_lvl  = sen_sy[SYNC_STAGES-1];
  wire sda      = sda_sy[SYNC_STAGES-1];
  wire sck_rise = sck & ~sck_q;
  wire wr_stb   = sen_lvl & ~sen_q;
  wire [ADDR_W-1:0] wr_addr = shreg[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sy <= '0;
      sen_sy <= '1;
      sda_sy <= '0;
      sck_q  <= 1'b0;
      sen_q  <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], ser_clk};
      sen_sy <= {sen_sy[SYNC_STAGES-2:0], ser_en_n};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], ser_dat};
      sck_q  <= sck;
      sen_q  <= sen_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      shreg <= '0;
    else if (sck_rise && !sen_lvl)
      shreg <= {shreg[FRAME_W-2:0], sda};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_sel   <= '0;
      low_pwr   <= 1'b0;
      auto_on   <= 1'b0;
      if_on_bit <= 1'b0;
      rf_on_bit <= 1'b0;
      n_rf1     <= '0;
      n_rf2     <= '0;
      n_if      <= '0;
      rf_band   <= 1'b0;
    end else if (wr_stb) begin
      case (wr_addr)
        A_MAIN: begin
          aux_sel <= shreg[ADDR_W+AUX_LSB +: 2];
          low_pwr <= shreg[ADDR_W+LPW_BIT];
          auto_on <= shreg[ADDR_W+AUT_BIT];
        end
        A_PWR: begin
          if_on_bit <= shreg[ADDR_W+PDI_BIT];
          rf_on_bit <= shreg[ADDR_W+PDR_BIT];
        end
        A_NRF1: begin
          n_rf1   <= shreg[FRAME_W-1:ADDR_W];
          rf_band <= 1'b0;
        end
        A_NRF2: begin
          n_rf2   <= shreg[FRAME_W-1:ADDR_W];
          rf_band <= 1'b1;
        end
        A_NIF: n_if <= shreg[ADDR_W +: IF_W];
        default: ;
      endcase
    end
  end

  assign if_en  = hw_pwr_n & (if_on_bit | auto_on);
  assign rf_en  = hw_pwr_n & (rf_on_bit | auto_on);
  assign ref_en = if_en | rf_en;
endmodule

// File: rtl/synth_ctl_port_chk.sv
module synth_ctl_port_chk #(
  parameter int DATA_W  = 18,
  parameter int IF_W    = 16,
  parameter int FRAME_W = 22
) (
  input logic               clk,
  input logic               rst,
  input logic               hw_pwr_n,
  input logic               sen_lvl,
  input logic               wr_stb,
  input logic [FRAME_W-1:0] shreg,
  input logic               auto_on,
  input logic [DATA_W-1:0]  n_rf1,
  input logic [DATA_W-1:0]  n_rf2,
  input logic [IF_W-1:0]    n_if,
  input logic               rf_band,
  input logic               if_en,
  input logic               rf_en,
  input logic               ref_en
);
  assert_pin_off_R6: assert property (@(posedge clk) disable iff (rst)
    !hw_pwr_n |-> (!if_en && !rf_en && !ref_en));

  assert_auto_forces_R7: assert property (@(posedge clk) disable iff (rst)
    (hw_pwr_n && auto_on) |-> (if_en && rf_en));

  assert_ref_needs_section_R8: assert property (@(posedge clk) disable iff (rst)
    ref_en |-> (if_en || rf_en));

  assert_section_lights_ref_R8: assert property (@(posedge clk) disable iff (rst)
    (if_en || rf_en) |-> ref_en);

  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
    sen_lvl |=> $stable(shreg));

  assert_write_on_commit_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable({n_rf1, n_rf2, n_if, rf_band}) |-> ($past(wr_stb) || $past(rst)));

  assert_rf1_band_R9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(n_rf1) && !$past(rst)) |-> !rf_band);

  assert_rf2_band_R9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(n_rf2) && !$past(rst)) |-> rf_band);
endmodule

bind synth_ctl_port synth_ctl_port_chk #(
  .DATA_W(DATA_W), .IF_W(IF_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .hw_pwr_n(hw_pwr_n), .sen_lvl(sen_lvl),
  .wr_stb(wr_stb), .shreg(shreg), .auto_on(auto_on),
  .n_rf1(n_rf1), .n_rf2(n_rf2), .n_if(n_if), .rf_band(rf_band),
  .if_en(if_en), .rf_en(rf_en), .ref_en(ref_en)
);

// File: tb/sim_synth_ctl_port.sv
module sim_synth_ctl_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1, hw_pwr_n = 1'b1;
  logic [1:0]  aux_sel;
  logic        low_pwr, auto_on, if_on_bit, rf_on_bit, rf_band, if_en, rf_en, ref_en;
  logic [17:0] n_rf1, n_rf2;
  logic [15:0] n_if;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  logic [1:0]  m_aux;
  logic        m_lpw, m_aut, m_pdi, m_pdr, m_band;
  logic [17:0] m_n1, m_n2;
  logic [15:0] m_nif;

  always #2 clk = ~clk;

  synth_ctl_port u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
    .hw_pwr_n(hw_pwr_n), .aux_sel(aux_sel), .low_pwr(low_pwr), .auto_on(auto_on),
    .if_on_bit(if_on_bit), .rf_on_bit(rf_on_bit), .n_rf1(n_rf1), .n_rf2(n_rf2),
    .n_if(n_if), .rf_band(rf_band), .if_en(if_en), .rf_en(rf_en), .ref_en(ref_en)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_aux = 0; m_lpw = 0; m_aut = 0; m_pdi = 0; m_pdr = 0;
    m_n1 = 0; m_n2 = 0; m_nif = 0; m_band = 0;
  endtask

  task automatic model_write(input logic [17:0] d, input logic [3:0] a);
    case (a)
      4'd0: begin m_aux = d[13:12]; m_lpw = d[5]; m_aut = d[3]; end
      4'd2: begin m_pdi = d[1]; m_pdr = d[0]; end
      4'd3: begin m_n1 = d; m_band = 1'b0; end
      4'd4: begin m_n2 = d; m_band = 1'b1; end
      4'd5: m_nif = d[15:0];
      default: ;
    endcase
  endtask

  task automatic check_all(input string req);
    logic e_if, e_rf;
    e_if = hw_pwr_n & (m_pdi | m_aut);
    e_rf = hw_pwr_n & (m_pdr | m_aut);
    check(aux_sel == m_aux, req, "aux_sel", 64'(aux_sel), 64'(m_aux));
    check(low_pwr == m_lpw, req, "low_pwr", 64'(low_pwr), 64'(m_lpw));
    check(auto_on == m_aut, req, "auto_on", 64'(auto_on), 64'(m_aut));
    check(if_on_bit == m_pdi, req, "if_on_bit", 64'(if_on_bit), 64'(m_pdi));
    check(rf_on_bit == m_pdr, req, "rf_on_bit", 64'(rf_on_bit), 64'(m_pdr));
    check(n_rf1 == m_n1, req, "n_rf1", 64'(n_rf1), 64'(m_n1));
    check(n_rf2 == m_n2, req, "n_rf2", 64'(n_rf2), 64'(m_n2));
    check(n_if == m_nif, req, "n_if", 64'(n_if), 64'(m_nif));
    check(rf_band == m_band, req, "rf_band", 64'(rf_band), 64'(m_band));
    check(if_en == e_if, req, "if_en", 64'(if_en), 64'(e_if));
    check(rf_en == e_rf, req, "rf_en", 64'(rf_en), 64'(e_rf));
    check(ref_en == (e_if | e_rf), req, "ref_en", 64'(ref_en), 64'(e_if | e_rf));
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b; wclk(4);
    ser_clk = 1'b1; wclk(4);
    ser_clk = 1'b0;
  endtask

  task automatic send_raw(input logic [63:0] v, input int n);
    ser_en_n = 1'b0; wclk(4);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    wclk(4); ser_en_n = 1'b1; wclk(10);
  endtask

  task automatic send_frame(input logic [17:0] d, input logic [3:0] a);
    send_raw(64'({d, a}), 22);
    model_write(d, a);
  endtask

  task automatic t_reset();
    model_reset();
    check_all("R12 after reset");
  endtask

  task automatic t_dividers();
    send_frame(18'h2A5C3, 4'd3);
    check_all("R1 RF1 divider");
    send_frame(18'h1F00F, 4'd4);
    check_all("R9 RF2 divider selects band");
    send_frame(18'h3ABCD, 4'd5);
    check_all("R5 IF divider upper bits dropped");
    send_frame(18'h00011, 4'd3);
    check_all("R9 RF1 reselected");
  endtask

  task automatic t_leading();
    send_raw({7'b1011011, 18'h01234, 4'd5}, 29);
    model_write(18'h01234, 4'd5);
    check_all("R3 leading bits discarded");
  endtask

  task automatic t_config();
    send_frame(18'h3E0D7 & ~18'h00008 | 18'h02020, 4'd0);
    check_all("R4 main config fields");
    send_frame(18'h01008, 4'd0);
    check_all("R4 main config second pattern");
  endtask

  task automatic t_power();
    send_frame(18'h0, 4'd0);
    for (int k = 0; k < 4; k++) begin
      send_frame(18'(k), 4'd2);
      check_all("R7 power bits");
      check(ref_en == (k != 0), "R8", "ref_en", 64'(ref_en), 64'(k != 0));
    end
    send_frame(18'h0, 4'd2);
    send_frame(18'h00008, 4'd0);
    check_all("R7 auto-on forces both");
    hw_pwr_n = 1'b0; wclk(2);
    check_all("R6 pin low forces off");
    send_frame(18'h2BEEF, 4'd4);
    check_all("R10 write while pin low");
    send_frame(18'h00003, 4'd2);
    send_frame(18'h0, 4'd0);
    check_all("R6 pin low with bits set");
    hw_pwr_n = 1'b1; wclk(2);
    check_all("R7 pin released");
  endtask

  task automatic t_reserved();
    send_frame(18'h3FFFF, 4'd1);
    check_all("R11 address 1 dropped");
    send_frame(18'h3FFFF, 4'd6);
    check_all("R11 address 6 dropped");
    send_frame(18'h15555, 4'd15);
    check_all("R11 address 15 dropped");
  endtask

  task automatic t_ignore();
    send_frame(18'h0ACE1, 4'd4);
    ser_dat = 1'b0; ser_en_n = 1'b1;
    shift_bit(1'b0); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    wclk(6);
    send_raw(64'h0, 0);
    check_all("R2 clocks with enable high ignored");
  endtask

  task automatic t_reset_again();
    rst = 1'b1; wclk(2); rst = 1'b0; wclk(2);
    model_reset();
    check_all("R12 mid-run reset");
  endtask

  initial begin
    model_reset();
    wclk(4); rst = 1'b0; wclk(4);
    t_reset();
    t_dividers();
    t_leading();
    t_config();
    t_power();
    t_reserved();
    t_ignore();
    t_reset_again();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule